// File: doc/BRIEF.md
# Clock Ratio Detector and Sync Monitor

This block runs on the system clock and watches a synchronous frame clock (one rising edge per sample). It times every frame in system clocks and, when the count lands close to 256, 384 or 512, takes that count as its locked reference. It then drives a qualifying enable, `en256_o`, that lets downstream filter and modulator logic see exactly 256 active cycles per frame whatever the real ratio is.

Once a reference is held, each new frame length is compared with it. A small amount of wander is accepted. A frame that is too long or too short, or a frame clock that stops, counts as loss of lock. The block then drops back to acquisition. While lock is absent, the capture data path outputs zero and the playback data path holds its last sample. Lock is declared again only after a fixed run of in-tolerance frames. The phase between the two clocks does not matter; only the frame length is judged.

Top module: `clk_ratio_sync_mon`

## Requirements
- R1: While acquiring, a measured frame (rising edge to rising edge of `lrck_i`) whose length is within TOL (4) system clocks of 256, 384 or 512 is captured as the reference. From the cycle after that edge, `ratio_o` shows 01, 10 or 11 respectively. Any other length leaves `ratio_o` at 00. Whenever `sync_o` is high, `ratio_o` is non-zero.
- R2: The first rising edge of `lrck_i` after reset only starts timing. It is never measured, even when the cycle count since reset would match a ratio.
- R3: While a reference is held, frame edges restart the enable phase. With cycle 0 as the cycle after an edge, `en256_o` is high on every cycle at ratio 01, on cycles where i mod 3 is not 2 at ratio 10, and on even cycles at ratio 11. While acquiring, `en256_o` is low.
- R4: A measured frame that differs from the reference by at most 4 bit clocks (64 bit clocks per frame) is ignored. That limit is 16, 24 or 32 system clocks for ratios 01, 10 and 11.
- R5: A measured frame that differs from the reference by more than that limit clears `sync_o` and `ratio_o` to 0 from the cycle after the edge, and acquisition restarts. The edge that caused the loss is not itself captured.
- R6: With a reference held and no edge arriving, once the elapsed count exceeds the reference plus the limit, lock is lost on that cycle and `sync_o` is 0 on the next.
- R7: `sync_o` rises in the cycle after the 32nd in-tolerance edge that follows the capturing edge, and not earlier.
- R8: If the 32nd edge is out of tolerance, loss wins. `sync_o` stays 0 and `ratio_o` returns to 00.
- R9: `cap_out` registers `cap_in` when `sync_o` was high at the clock edge, and zero otherwise.
- R10: `play_out` registers `play_in` when `sync_o` was high at the clock edge, and otherwise keeps its value.
- R11: During reset, `sync_o`, `en256_o`, `ratio_o`, `cap_out` and `play_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lrck_i | input | 1 | Frame clock, synchronous to clk |
| cap_in | input | DW | Capture-path sample from the converter |
| play_in | input | DW | Playback-path sample toward the converter |
| en256_o | output | 1 | Qualifying enable, 256 active cycles per frame |
| sync_o | output | 1 | Lock held |
| ratio_o | output | 2 | 00 none, 01 256x, 10 384x, 11 512x |
| cap_out | output | DW | Gated capture sample |
| play_out | output | DW | Held playback sample |

## Verification
Two events can land on the same frame edge: the settle counter finishing its 32nd good frame, and the drift check rejecting that same frame. The bench provokes this at the 384x ratio. It stretches the final frame of the settle window to 409 clocks, one beyond the 24-clock limit. At that edge it expects `sync_o` to stay low and `ratio_o` to fall to 00. After that, a clean 512x frame must be captured from scratch.

// File: rtl/crsm_pkg.sv
package crsm_pkg;

  typedef enum logic [1:0] {
    RATIO_NONE = 2'd0,
    RATIO_256  = 2'd1,
    RATIO_384  = 2'd2,
    RATIO_512  = 2'd3
  } ratio_e;

  typedef enum logic [1:0] {
    ST_ACQ    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LOCK   = 2'd2
  } lock_st_e;

  function automatic int unsigned abs_gap(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic int unsigned ratio_mult(ratio_e r);
    case (r)
      RATIO_256: return 256;
      RATIO_384: return 384;
      RATIO_512: return 512;
      default:   return 0;
    endcase
  endfunction

  // nearest supported ratio within tol system clocks, else none
  function automatic ratio_e classify_ratio(int unsigned period, int unsigned tol);
    if (abs_gap(period, 256) <= tol) return RATIO_256;
    if (abs_gap(period, 384) <= tol) return RATIO_384;
    if (abs_gap(period, 512) <= tol) return RATIO_512;
    return RATIO_NONE;
  endfunction

  // drift tolerance converted from bit clocks into system clocks
  function automatic int unsigned drift_limit(ratio_e r, int unsigned bck_per_frame,
                                              int unsigned drift_bck);
    return (drift_bck * ratio_mult(r)) / bck_per_frame;
  endfunction

  function automatic logic [1:0] phase_last(ratio_e r);
    case (r)
      RATIO_384: return 2'd2;
      RATIO_512: return 2'd1;
      default:   return 2'd0;
    endcase
  endfunction

  function automatic logic en_pattern(ratio_e r, logic [1:0] ph);
    case (r)
      RATIO_256: return 1'b1;
      RATIO_384: return ph != 2'd2;
      RATIO_512: return ph == 2'd0;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/crsm_frame_meter.sv
module crsm_frame_meter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrck,
  output logic             rise,
  output logic             period_ok,
  output logic [CNT_W-1:0] elapsed
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lrck_q;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;

  assign rise      = lrck & ~lrck_q;
  assign period_ok = rise & seen_q;   // first edge only opens the window
  assign elapsed   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lrck_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      lrck_q <= lrck;
      if (rise) begin
        seen_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assert_edge_restarts_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (elapsed == CNT_W'(1)));

endmodule

// File: rtl/crsm_rate_divider.sv
module crsm_rate_divider
  import crsm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   rise,
  input  ratio_e ratio,
  output logic   en
);
  logic [1:0] ph_q;

  assign en = run && en_pattern(ratio, ph_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= 2'd0;
    end else if (!run || rise) begin
      ph_q <= 2'd0;
    end else if (ph_q == phase_last(ratio)) begin
      ph_q <= 2'd0;
    end else begin
      ph_q <= ph_q + 2'd1;
    end
  end

  // two of every three cycles at 384x while no edge disturbs the phase
  assert_two_of_three_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ratio == RATIO_384 && $past(run && ratio == RATIO_384)
     && $past(run && ratio == RATIO_384, 2) && !$past(rise) && !$past(rise, 2))
    |-> ($countones({en, $past(en), $past(en, 2)}) == 2));

endmodule

// File: rtl/crsm_lock_fsm.sv
module crsm_lock_fsm
  import crsm_pkg::*;
#(
  parameter int unsigned CNT_W         = 11,
  parameter int unsigned TOL           = 4,
  parameter int unsigned BCK_PER_FRAME = 64,
  parameter int unsigned DRIFT_BCK     = 4,
  parameter int unsigned HOLD_FRAMES   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             period_ok,
  input  logic [CNT_W-1:0] elapsed,
  output logic             sync,
  output ratio_e           ratio,
  output logic             run
);
  localparam int unsigned FRM_W = (HOLD_FRAMES > 1) ? $clog2(HOLD_FRAMES) : 1;
  localparam int unsigned LIM_W = CNT_W + 1;

  lock_st_e         state_q;
  logic [CNT_W-1:0] ref_q;
  ratio_e           ratio_q;
  logic [FRM_W-1:0] frm_q;

  logic [LIM_W-1:0] thr, limit;
  ratio_e           seen_ratio;
  logic             drift_bad, timeout, loss;

  always_comb begin
    thr        = LIM_W'(drift_limit(ratio_q, BCK_PER_FRAME, DRIFT_BCK));
    limit      = {1'b0, ref_q} + thr;
    seen_ratio = classify_ratio(32'(elapsed), TOL);
    drift_bad  = period_ok && (LIM_W'(abs_gap(32'(elapsed), 32'(ref_q))) > thr);
    timeout    = !rise && ({1'b0, elapsed} > limit);
    loss       = (state_q != ST_ACQ) && (drift_bad || timeout);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ACQ;
      ref_q   <= '0;
      ratio_q <= RATIO_NONE;
      frm_q   <= '0;
    end else begin
      unique case (state_q)
        ST_ACQ: begin
          if (period_ok && seen_ratio != RATIO_NONE) begin
            state_q <= ST_SETTLE;
            ref_q   <= elapsed;
            ratio_q <= seen_ratio;
            frm_q   <= '0;
          end
        end
        default: begin
          if (loss) begin
            state_q <= ST_ACQ;
            ratio_q <= RATIO_NONE;
          end else if (period_ok && state_q == ST_SETTLE) begin
            if (frm_q == FRM_W'(HOLD_FRAMES - 1)) state_q <= ST_LOCK;
            else                                  frm_q   <= frm_q + FRM_W'(1);
          end
        end
      endcase
    end
  end

  assign sync  = (state_q == ST_LOCK);
  assign ratio = ratio_q;
  assign run   = (state_q != ST_ACQ);

  assert_drift_exits_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && drift_bad) |=> (!run && ratio == RATIO_NONE));

  assert_lock_only_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> $past(period_ok));

  assert_silent_frame_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> ({1'b0, elapsed} <= limit + LIM_W'(1)));

  assert_loss_beats_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE && loss) |=> !sync);

endmodule

// File: rtl/clk_ratio_sync_mon.sv
module clk_ratio_sync_mon
  import crsm_pkg::*;
#(
  parameter int unsigned DW            = 16,
  parameter int unsigned CNT_W         = 11,
  parameter int unsigned TOL           = 4,
  parameter int unsigned BCK_PER_FRAME = 64,
  parameter int unsigned DRIFT_BCK     = 4,
  parameter int unsigned HOLD_FRAMES   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lrck_i,
  input  logic [DW-1:0] cap_in,
  input  logic [DW-1:0] play_in,
  output logic          en256_o,
  output logic          sync_o,
  output logic [1:0]    ratio_o,
  output logic [DW-1:0] cap_out,
  output logic [DW-1:0] play_out
);
  logic             rise_w, period_ok_w, run_w;
  logic [CNT_W-1:0] elapsed_w;
  ratio_e           ratio_w;

  crsm_frame_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .lrck(lrck_i),
    .rise(rise_w), .period_ok(period_ok_w), .elapsed(elapsed_w)
  );

  crsm_lock_fsm #(
    .CNT_W(CNT_W), .TOL(TOL), .BCK_PER_FRAME(BCK_PER_FRAME),
    .DRIFT_BCK(DRIFT_BCK), .HOLD_FRAMES(HOLD_FRAMES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise(rise_w), .period_ok(period_ok_w),
    .elapsed(elapsed_w), .sync(sync_o), .ratio(ratio_w), .run(run_w)
  );

  crsm_rate_divider u_div (
    .clk(clk), .rst_n(rst_n), .run(run_w), .rise(rise_w),
    .ratio(ratio_w), .en(en256_o)
  );

  assign ratio_o = ratio_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_out  <= '0;
      play_out <= '0;
    end else begin
      cap_out <= sync_o ? cap_in : '0;
      if (sync_o) play_out <= play_in;
    end
  end

  assert_capture_zeroed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_o |=> (cap_out == '0));

  assert_playback_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_o |=> $stable(play_out));

  assert_ratio_known_in_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> (ratio_o != 2'b00));

endmodule

// File: tb/tb_clk_ratio_sync_mon.sv
`timescale 1ns/1ps
module tb_clk_ratio_sync_mon;

  localparam int K_SYNC = 0, K_RATIO = 1, K_EN = 2, K_CAP = 3, K_PLAY = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lrck;
  logic [15:0] cap_in, play_in;
  logic        en256_o, sync_o;
  logic [1:0]  ratio_o;
  logic [15:0] cap_out, play_out;

  typedef struct {
    string       tag;
    int          kind;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad   = 0;
  bit    finished = 0;

  always #10 clk = ~clk;

  clk_ratio_sync_mon dut (
    .clk(clk), .rst_n(rst_n), .lrck_i(lrck), .cap_in(cap_in), .play_in(play_in),
    .en256_o(en256_o), .sync_o(sync_o), .ratio_o(ratio_o),
    .cap_out(cap_out), .play_out(play_out)
  );

  // monitor: compares queued expectations mid-cycle
  initial begin
    forever begin
      @(posedge clk);
      #7;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.kind)
          K_SYNC:  act = {15'd0, sync_o};
          K_RATIO: act = {14'd0, ratio_o};
          K_EN:    act = {15'd0, en256_o};
          K_CAP:   act = cap_out;
          default: act = play_out;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic want(string tag, int kind, logic [15:0] v);
    item_t it;
    it.tag = tag;
    it.kind = kind;
    it.exp = v;
    q.push_back(it);
  endtask

  function automatic logic en_of(int mul, int i);
    if (mul == 256) return 1'b1;
    if (mul == 384) return (i % 3) != 2;
    return (i % 2) == 0;
  endfunction

  task automatic frame_start();
    lrck = 1'b1;
    tick();
  endtask

  task automatic frame_rest(int p, int from, int mul);
    for (int i = from; i < p; i++) begin
      if (i == p / 2) lrck = 1'b0;
      tick();
      if (mul != 0) want("R3 enable pattern", K_EN, {15'd0, en_of(mul, i)});
    end
  endtask

  initial begin
    rst_n = 1'b0; lrck = 1'b0; cap_in = 16'hBEEF; play_in = 16'hCAFE;
    repeat (3) tick();
    want("R11 reset sync", K_SYNC, 16'd0);
    want("R11 reset ratio", K_RATIO, 16'd0);
    want("R11 reset enable", K_EN, 16'd0);
    want("R11 reset capture", K_CAP, 16'd0);
    want("R11 reset playback", K_PLAY, 16'd0);
    rst_n = 1'b1;
    repeat (256) tick();

    frame_start();                       // first edge, 256 cycles after reset
    want("R2 first edge not measured", K_RATIO, 16'd0);
    frame_rest(256, 1, 0);

    frame_start();                       // capture at 256x
    want("R1 capture 256x ratio", K_RATIO, 16'd1);
    want("R7 no lock at capture", K_SYNC, 16'd0);
    want("R3 enable pattern", K_EN, 16'd1);
    frame_rest(256, 1, 256);

    for (int k = 2; k <= 32; k++) begin
      frame_start();
      if (k == 32) want("R7 no lock at edge 31", K_SYNC, 16'd0);
      frame_rest(256, 1, 0);
    end

    frame_start();                       // 32nd good edge
    want("R7 lock at edge 32", K_SYNC, 16'd1);
    want("R1 ratio in lock", K_RATIO, 16'd1);
    cap_in = 16'hA5C3; play_in = 16'h1234;
    tick();
    want("R9 capture passes in lock", K_CAP, 16'hA5C3);
    want("R10 playback passes in lock", K_PLAY, 16'h1234);
    frame_rest(272, 2, 0);

    frame_start();
    want("R4 +16 drift ignored", K_SYNC, 16'd1);
    frame_rest(240, 1, 0);
    frame_start();
    want("R4 -16 drift ignored", K_SYNC, 16'd1);
    frame_rest(273, 1, 0);

    cap_in = 16'h1111; play_in = 16'h2222;
    frame_start();                       // +17 drift
    want("R5 drift loss clears sync", K_SYNC, 16'd0);
    want("R5 drift loss clears ratio", K_RATIO, 16'd0);
    want("R10 last sample taken", K_PLAY, 16'h2222);
    cap_in = 16'h4444; play_in = 16'h3333;
    tick();
    want("R9 capture zero after loss", K_CAP, 16'd0);
    want("R10 playback held after loss", K_PLAY, 16'h2222);
    want("R3 no enable while acquiring", K_EN, 16'd0);
    frame_rest(300, 2, 0);

    frame_start();
    want("R1 out-of-window length ignored", K_RATIO, 16'd0);
    frame_rest(384, 1, 0);

    frame_start();                       // capture at 384x
    want("R1 capture 384x ratio", K_RATIO, 16'd2);
    want("R3 enable pattern", K_EN, 16'd1);
    frame_rest(384, 1, 384);

    for (int j = 1; j <= 31; j++) begin
      frame_start();
      if (j == 6)  want("R4 +24 drift ignored at 384x", K_RATIO, 16'd2);
      if (j == 31) want("R7 no lock at edge 31", K_SYNC, 16'd0);
      frame_rest((j == 5) ? 408 : ((j == 31) ? 409 : 384), 1, 0);
    end

    frame_start();                       // edge 32 out of tolerance
    want("R8 loss wins over lock", K_SYNC, 16'd0);
    want("R8 ratio cleared", K_RATIO, 16'd0);
    frame_rest(512, 1, 0);

    frame_start();                       // capture at 512x
    want("R1 capture 512x ratio", K_RATIO, 16'd3);
    want("R3 enable pattern", K_EN, 16'd1);
    frame_rest(512, 1, 512);

    for (int j = 1; j <= 31; j++) begin
      frame_start();
      frame_rest(512, 1, 0);
    end
    frame_start();
    want("R7 lock at 512x", K_SYNC, 16'd1);
    want("R1 ratio in lock", K_RATIO, 16'd3);
    for (int i = 1; i <= 544; i++) begin   // frame clock stops low
      if (i == 256) lrck = 1'b0;
      tick();
    end
    want("R6 still locked at limit", K_SYNC, 16'd1);
    tick();
    want("R6 timeout loss", K_SYNC, 16'd0);
    tick();
    want("R9 capture zero after timeout", K_CAP, 16'd0);
    tick();
    tick();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule